// File: doc/BRIEF.md
# Radius-Two Local Binary Pattern Stream Generator

This block turns a raster stream of 8-bit grayscale pixels into a stream of 8-bit texture codes. Each code describes one centre pixel. Eight samples lie on a circle of radius two around that centre. Each sample is compared with the centre, and the eight comparison results are packed into a byte. The four samples on the axes are taken straight from pixels two positions away. The four diagonal samples fall between grid points, so each one is blended from its surrounding 2x2 pixel block with fixed-point bilinear weights.

Pixels enter one per accepted cycle. `in_sof` marks the first pixel of a frame and `in_sol` marks the first pixel of every line. Four line stores and a five-by-five register window hold the five rows that each code needs. Every accepted pixel completes the window for the centre two rows up and two columns to the left, and produces one result slot. The slots therefore come out in raster order, two lines plus two pixels behind the input. A slot whose centre lies within two pixels of any frame edge is marked not valid.

Top module: `lbp_r2_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `code_tick`, `code_valid` and `code` are all zero.
- R2: Every cycle with `in_valid` high produces exactly one `code_tick` pulse, two clock cycles later. Slots leave in the order their pixels arrived, and no tick appears without an accepted pixel.
- R3: Rows and columns are numbered from 0. The slot for the input pixel at row r, column c describes the centre (r-2, c-2). `code_valid` is high only when r >= 4 and c >= 4, so any centre within two pixels of an edge is reported as not valid. A slot that is not valid carries `code` = 0.
- R4: The axis bits are bit 0 = left (same row, column -2), bit 2 = bottom (row +2), bit 4 = right (column +2) and bit 6 = top (row -2). Each axis bit is 1 when that pixel is greater than or equal to the centre.
- R5: The diagonal bits are bit 1 = lower-left, bit 3 = lower-right, bit 5 = upper-right and bit 7 = upper-left. For each diagonal, the sum 88*near + 62*(two mixed pixels) + 44*far is taken over its 2x2 block. "Near" is the pixel at offset (±1, ±1) and "far" is the pixel at offset (±2, ±2). The bit is 1 when this sum is greater than or equal to 256 times the centre, with no rounding.
- R6: A tie sets the bit. A flat region yields code 255, and a diagonal sum that falls short of 256*centre by even one weight step clears that bit.
- R7: An accepted `in_sof` restarts the row and column count at (0,0). Rows left in the line stores from an earlier frame never produce a valid code in the new frame.
- R8: Cycles with `in_valid` low do not advance the window, the line stores or the counters, whatever `in_sof`, `in_sol` and `in_pix` carry. Idle gaps in the input therefore leave every code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | PIX_W | Grayscale pixel |
| code_tick | output | 1 | One result slot per accepted pixel |
| code_valid | output | 1 | Slot centre is interior; code is meaningful |
| code | output | 8 | Pattern code, zero when not valid |

## Verification
The bench goes after the first four rows and columns of every frame. A design with an off-by-one in the border rule either flags a wrapped or half-filled window as valid or drops the first interior code. Flat and near-flat frames test the tie rule: a design that uses a strict comparison, or rounds the weighted diagonal sum, gives 0 instead of 255 or flips single diagonal bits. A checkerboard, a ramp and random frames cover bit placement, where a swapped neighbour or mirrored weight shows up as a wrong bit in the axis or diagonal half of the code. Idle gaps with stray frame and line markers, plus back-to-back frames of different heights, expose designs that shift on idle cycles or carry stale rows across a frame start.

// File: rtl/lbp_r2_pkg.sv
package lbp_r2_pkg;

    // Window geometry: radius-two neighbourhood gives a 5x5 window, centre at index 2.
    localparam int RAD  = 2;
    localparam int WIN  = 2 * RAD + 1;
    localparam int CTR  = RAD;

    // Interpolation weights in unsigned Q0.8, total 256.
    localparam int FRAC  = 8;
    localparam int SUM_W = 26;
    localparam logic [SUM_W-1:0] W_NEAR = SUM_W'(88);
    localparam logic [SUM_W-1:0] W_MID  = SUM_W'(62);
    localparam logic [SUM_W-1:0] W_FAR  = SUM_W'(44);

    // Per-slot control carried alongside the window.
    typedef struct packed {
        logic tick;
        logic interior;
    } slot_t;

    // Weighted 2x2 blend for one off-grid diagonal sample.
    function automatic logic [SUM_W-1:0] blend4(
        input logic [15:0] near_px,
        input logic [15:0] mid_a,
        input logic [15:0] mid_b,
        input logic [15:0] far_px
    );
        return SUM_W'(near_px) * W_NEAR
             + SUM_W'(mid_a)   * W_MID
             + SUM_W'(mid_b)   * W_MID
             + SUM_W'(far_px)  * W_FAR;
    endfunction

endpackage

// File: rtl/lbp_r2_linebuf.sv
module lbp_r2_linebuf #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);
    logic [PIX_W-1:0] mem [DEPTH];

    // Read-before-write: the old entry is the same column one line earlier.
    assign dout = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= din;
        end
    end
endmodule

// File: rtl/lbp_r2_pos.sv
module lbp_r2_pos import lbp_r2_pkg::*; #(
    parameter int IMG_W = 16,
    parameter int ROW_W = 12,
    localparam int COL_W = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    output logic [COL_W-1:0] cur_col,
    output logic             interior
);
    localparam logic [ROW_W-1:0] ROW_MAX = '1;
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_MIN = ROW_W'(2 * RAD);
    localparam logic [COL_W-1:0] COL_MIN = COL_W'(2 * RAD);

    logic [ROW_W-1:0] row_q, cur_row;
    logic [COL_W-1:0] col_q;

    always_comb begin
        if (in_sof) begin
            cur_row = '0;
            cur_col = '0;
        end else if (in_sol) begin
            cur_row = (row_q == ROW_MAX) ? row_q : row_q + 1'b1;
            cur_col = '0;
        end else begin
            cur_row = row_q;
            cur_col = (col_q == COL_MAX) ? col_q : col_q + 1'b1;
        end
        interior = (cur_row >= ROW_MIN) && (cur_col >= COL_MIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (in_valid) begin
            row_q <= cur_row;
            col_q <= cur_col;
        end
    end
endmodule

// File: rtl/lbp_r2_window.sv
module lbp_r2_window import lbp_r2_pkg::*; #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [PIX_W-1:0] col_in [WIN],
    output logic [PIX_W-1:0] win    [WIN][WIN]
);
    // win[row][col]: row 0 is the oldest line, col WIN-1 the newest column.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN; c++) begin
                    win[r][c] <= '0;
                end
            end
        end else if (adv) begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN - 1; c++) begin
                    win[r][c] <= win[r][c+1];
                end
                win[r][WIN-1] <= col_in[r];
            end
        end
    end
endmodule

// File: rtl/lbp_r2_core.sv
module lbp_r2_core import lbp_r2_pkg::*; #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slot_in,
    input  logic [PIX_W-1:0] win [WIN][WIN],
    output logic             code_tick,
    output logic             code_valid,
    output logic [7:0]       code
);
    logic [PIX_W-1:0] ctr_px;
    logic [SUM_W-1:0] ctr_scaled;
    logic [3:0]       axis_bit;
    logic [3:0]       diag_bit;
    logic [7:0]       bits;

    assign ctr_px     = win[CTR][CTR];
    assign ctr_scaled = SUM_W'(ctr_px) << FRAC;

    // Axis samples: d=0 left, 1 bottom, 2 right, 3 top -> code bit 2d.
    for (genvar d = 0; d < 4; d++) begin : g_axis
        localparam int DR = (d == 1) ? RAD : (d == 3) ? -RAD : 0;
        localparam int DC = (d == 0) ? -RAD : (d == 2) ? RAD : 0;
        assign axis_bit[d] = win[CTR+DR][CTR+DC] >= ctr_px;
        assign bits[2*d]   = axis_bit[d];
    end

    // Diagonal samples: d=0 lower-left, 1 lower-right, 2 upper-right, 3 upper-left -> bit 2d+1.
    for (genvar d = 0; d < 4; d++) begin : g_diag
        localparam int DR = (d < 2) ? 1 : -1;
        localparam int DC = (d == 0 || d == 3) ? -1 : 1;
        logic [SUM_W-1:0] sum;
        assign sum = blend4(16'(win[CTR+DR][CTR+DC]),
                            16'(win[CTR+2*DR][CTR+DC]),
                            16'(win[CTR+DR][CTR+2*DC]),
                            16'(win[CTR+2*DR][CTR+2*DC]));
        assign diag_bit[d]   = sum >= ctr_scaled;
        assign bits[2*d+1]   = diag_bit[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_tick  <= 1'b0;
            code_valid <= 1'b0;
            code       <= '0;
        end else begin
            code_tick  <= slot_in.tick;
            code_valid <= slot_in.tick & slot_in.interior;
            code       <= (slot_in.tick && slot_in.interior) ? bits : '0;
        end
    end
endmodule

// File: rtl/lbp_r2_gen.sv
module lbp_r2_gen import lbp_r2_pkg::*; #(
    parameter int IMG_W = 16,
    parameter int PIX_W = 8,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             code_tick,
    output logic             code_valid,
    output logic [7:0]       code
);
    localparam int COL_W = $clog2(IMG_W);
    localparam int NLB   = WIN - 1;

    logic [COL_W-1:0] cur_col;
    logic             interior;
    logic [PIX_W-1:0] chain  [NLB];
    logic [PIX_W-1:0] col_vec[WIN];
    logic [PIX_W-1:0] win    [WIN][WIN];
    slot_t            slot_q;

    lbp_r2_pos #(.IMG_W(IMG_W), .ROW_W(ROW_W)) u_pos (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .cur_col(cur_col), .interior(interior)
    );

    // Cascade of line stores: store k outputs the row k+1 lines above the input.
    for (genvar k = 0; k < NLB; k++) begin : g_lb
        logic [PIX_W-1:0] lb_din;
        if (k == 0) begin : g_head
            assign lb_din = in_pix;
        end else begin : g_link
            assign lb_din = chain[k-1];
        end
        lbp_r2_linebuf #(.PIX_W(PIX_W), .DEPTH(IMG_W)) u_lb (
            .clk(clk), .wr_en(in_valid), .addr(cur_col),
            .din(lb_din), .dout(chain[k])
        );
        assign col_vec[WIN-2-k] = chain[k];
    end
    assign col_vec[WIN-1] = in_pix;

    lbp_r2_window #(.PIX_W(PIX_W)) u_win (
        .clk(clk), .rst(rst), .adv(in_valid), .col_in(col_vec), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q.tick     <= in_valid;
            slot_q.interior <= interior;
        end
    end

    lbp_r2_core #(.PIX_W(PIX_W)) u_core (
        .clk(clk), .rst(rst), .slot_in(slot_q), .win(win),
        .code_tick(code_tick), .code_valid(code_valid), .code(code)
    );
endmodule

// File: rtl/lbp_r2_gen_chk.sv
module lbp_r2_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sof,
    input logic       code_tick,
    input logic       code_valid,
    input logic [7:0] code
);
    // R1: outputs quiet out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!code_tick && !code_valid && code == 8'd0));

    // R2: accepted pixel yields a tick two cycles on
    p_tick_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 code_tick);

    // R2 / R8: no tick without an accepted pixel
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        code_tick |-> $past(in_valid, 2));

    // R3: valid only within a slot
    p_valid_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> code_tick);

    // R3: border slots carry zero
    p_border_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !code_valid |-> code == 8'd0);

    // R7: frame start pixel is a border slot
    p_sof_border_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |-> ##2 (code_tick && !code_valid));
endmodule

bind lbp_r2_gen lbp_r2_gen_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .code_tick(code_tick), .code_valid(code_valid), .code(code)
);

// File: tb/lbp_r2_gen_test.sv
module lbp_r2_gen_test;
    localparam int W = 16;
    localparam int HMAX = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_sol = 1'b0;
    logic [7:0] in_pix = 8'd0;
    logic       code_tick;
    logic       code_valid;
    logic [7:0] code;

    always #5 clk = ~clk;

    lbp_r2_gen #(.IMG_W(W), .PIX_W(8), .ROW_W(12)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_pix(in_pix), .code_tick(code_tick),
        .code_valid(code_valid), .code(code)
    );

    typedef struct {
        bit       v;
        bit [7:0] c;
        string    tag;
        int       cyc;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   img [HMAX][W];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit dsamp(int r, int c, int dr, int dc);
        int s;
        s = 88 * img[r+dr][c+dc] + 62 * img[r+2*dr][c+dc]
          + 62 * img[r+dr][c+2*dc] + 44 * img[r+2*dr][c+2*dc];
        return s >= img[r][c] * 256;
    endfunction

    // Expected code for centre (r,c), bit layout per R4 and R5.
    function automatic bit [7:0] model(int r, int c);
        bit [7:0] b;
        int p;
        p = img[r][c];
        b[0] = img[r][c-2] >= p;
        b[1] = dsamp(r, c,  1, -1);
        b[2] = img[r+2][c] >= p;
        b[3] = dsamp(r, c,  1,  1);
        b[4] = img[r][c+2] >= p;
        b[5] = dsamp(r, c, -1,  1);
        b[6] = img[r-2][c] >= p;
        b[7] = dsamp(r, c, -1, -1);
        return b;
    endfunction

    task automatic idle(input bit noisy);
        in_valid = 1'b0;
        in_sof   = noisy ? 1'($urandom_range(1)) : 1'b0;
        in_sol   = noisy ? 1'($urandom_range(1)) : 1'b0;
        in_pix   = noisy ? 8'($urandom_range(255)) : 8'd0;
        @(negedge clk);
    endtask

    task automatic drive_pix(input int r, input int c, input int pix, input string tag);
        exp_t e;
        img[r][c] = pix;
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_sol   = (c == 0);
        in_pix   = 8'(pix);
        e.tag = tag;
        e.cyc = cyc;
        if (r >= 4 && c >= 4) begin
            e.v = 1'b1;
            e.c = model(r - 2, c - 2);
        end else begin
            e.v = 1'b0;
            e.c = 8'd0;
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    // mode: 0 random, 1 flat, 2 checkerboard, 3 ramp, 4 near-flat ties
    task automatic run_frame(input int h, input int mode, input string tag, input int gap_pct);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < W; c++) begin
                int pix;
                case (mode)
                    1: pix = 77;
                    2: pix = ((r + c) % 2 == 1) ? 200 : 50;
                    3: pix = (r * 13 + c * 7) % 256;
                    4: pix = ((r % 2 == 0) && (c % 2 == 0)) ? 99 : 100;
                    default: pix = $urandom_range(255);
                endcase
                while ($urandom_range(99) < gap_pct) idle(1'b1);
                drive_pix(r, c, pix, tag);
            end
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && code_tick) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "tick with empty queue", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc == e.cyc + 2, "R2", {"latency ", e.tag}, cyc - e.cyc, 2);
                chk(code_valid == e.v, "R3", {"valid flag ", e.tag}, code_valid, e.v);
                if (e.v) begin
                    chk((code & 8'h55) == (e.c & 8'h55), "R4",
                        {"axis bits ", e.tag}, code & 8'h55, e.c & 8'h55);
                    chk((code & 8'hAA) == (e.c & 8'hAA), "R5",
                        {"diagonal bits ", e.tag}, code & 8'hAA, e.c & 8'hAA);
                end else begin
                    chk(code == 8'd0, "R3", {"border code ", e.tag}, code, 0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: cycles=%0d expected completion before 40000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(code_tick == 1'b0, "R1", "tick in reset", code_tick, 0);
        chk(code_valid == 1'b0, "R1", "valid in reset", code_valid, 0);
        chk(code == 8'd0, "R1", "code in reset", code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(code_tick == 1'b0 && code == 8'd0, "R1", "after reset", code, 0);

        run_frame(8, 0, "R5 random", 0);
        run_frame(6, 1, "R6 flat", 0);
        run_frame(7, 2, "R4 checker", 0);
        run_frame(6, 3, "R8 ramp gaps", 30);
        run_frame(7, 4, "R6 ties", 0);
        run_frame(5, 0, "R7 short frame", 0);
        run_frame(9, 0, "R7 restart gaps", 20);
        run_frame(6, 1, "R6 flat again", 10);

        repeat (6) idle(1'b1);
        chk(q.size() == 0, "R2", "pending slots at end", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule